// File: doc/BRIEF.md
# Lockstep PWM Group Update Controller

This block manages double-buffered updates for a group of PWM channels that advance in lockstep. A stream port delivers new duty-cycle values, one beat per enabled channel, into per-channel shadow registers. A simple register port lets the CPU stage a new period, a new pair of dead-time values, an update interval, an interrupt mask and a timing option. The waveform counter sits outside the block. It reports each group period boundary through `period_tick` and, optionally, a compare-match event through `cmp_match`.

Duty values and the update interval are committed together and without software action once every `interval + 1` period boundaries. The period and dead-time values follow a different path. The CPU arms them with a self-clearing unlock bit, and they take effect at the next period boundary. Two sticky status flags report the state of the duty path: one says a new set is wanted, the other says an interval expired before the set was complete. Reading the status clears both. Each flag can raise the interrupt output through its own mask bit.

The duty port uses valid/ready handshaking. A beat transfers on any clock edge where `dty_valid` and `dty_ready` are both high. `dty_ready` goes high only while a fill window is open and fewer beats than enabled channels have arrived. Once the window has taken its last beat, `dty_ready` stays low until the next window opens, and the sender must hold its data while ready is low. `dma_req` mirrors `dty_ready` so that a DMA engine can pace itself from it.

Top module: `sync_pwm_upd_ctrl`

## Requirements
- R1: Values written to the period register (address 0, bits [15:0]) and the dead-time register (address 1, low-side in [7:0], high-side in [15:8]) appear on `act_period`, `act_dt_lo` and `act_dt_hi` only through an unlock. While `unlock_pend` is 0, period boundaries leave those outputs unchanged.
- R2: Writing 1 to bit 0 of the control register (address 3) sets `unlock_pend`. The bit then stays 1 until the next `period_tick`, which copies the staged period and dead-times to the active outputs and clears the bit. A write with bit 0 at 0 has no effect.
- R3: The interval register (address 2, bits [7:0]) is loaded into an internal down-counter at every commit. A commit occurs on a `period_tick` that finds the counter at 0, so commits are `interval + 1` boundaries apart. Out of reset the counter is 0, so the first boundary commits.
- R4: Accepted duty beats fill the enabled channels of `ch_en` in ascending index order. Beat k of a set goes to the k-th enabled channel. With mask 4'b1011, beats go to channels 0, 1 and 3.
- R5: `dty_ready` and `dma_req` are high exactly while a fill window is open and fewer beats than enabled channels have been accepted. They fall in the cycle after the last enabled channel's beat.
- R6: A commit that finds a complete set, including a beat accepted on the commit edge itself, copies every enabled channel's shadow value to its slice of `act_duty` (channel i at bits [16i+15:16i]). Disabled channels keep their active value. No other event changes `act_duty`.
- R7: A commit that finds an open window with an incomplete set sets the underrun flag (`stat_flags[1]`). It leaves `act_duty` unchanged and discards the partial set, so the next set starts again at the lowest enabled channel.
- R8: The ready flag (`stat_flags[0]`) is set when a fill window opens. A `stat_rd` pulse clears both flags. A flag set in the same cycle as a read stays set.
- R9: `irq` is high while any status flag is set whose bit in the mask register (address 4; bit 0 ready, bit 1 underrun) is 1.
- R10: In default timing (bit 0 of address 5 is 0), every commit opens a new fill window. When that bit is 1, a commit closes the window and only a `cmp_match` pulse opens the next one, setting the ready flag and raising `dma_req`.
- R11: After reset, all active outputs, flags, `unlock_pend`, `irq`, `dma_req` and `dty_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_tick | input | 1 | One-cycle strobe at each group period boundary |
| cmp_match | input | 1 | One-cycle compare-match strobe, used in compare timing |
| ch_en | input | 4 | Mask of channels that take part in the group |
| dty_valid | input | 1 | Duty beat valid |
| dty_ready | output | 1 | Duty beat accepted when high together with valid |
| dty_data | input | 16 | Duty value |
| dma_req | output | 1 | Transfer request for the duty stream |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| stat_rd | input | 1 | Status read strobe; clears both flags |
| stat_flags | output | 2 | {underrun, ready} |
| unlock_pend | output | 1 | Period/dead-time unlock waiting for a boundary |
| irq | output | 1 | Masked interrupt |
| act_period | output | 16 | Active period |
| act_dt_hi | output | 8 | Active high-side dead time |
| act_dt_lo | output | 8 | Active low-side dead time |
| act_duty | output | 64 | Active duty values, channel i at [16i+15:16i] |

## Verification
The duty path is swept over all sixteen channel masks and three interval values. Each mask/interval pair runs three sets in turn: a complete set, then a short set one beat shy, then another complete set. The first set shows whether beats land on the right channels in rank order and whether the commit waits exactly `interval + 1` boundaries. The short set separates the underrun path from a normal commit. The final set would come out shifted by one channel if the partial index were not reset. Directed sequences cover the unlock path (idle boundaries before and after the unlock), interrupt masking of each flag alone, and compare timing, where a commit alone must not reopen the window.

// File: rtl/upd_pkg.sv
package upd_pkg;
  typedef enum logic [2:0] {
    A_PERIOD = 3'd0,
    A_DTIME  = 3'd1,
    A_IVAL   = 3'd2,
    A_CTRL   = 3'd3,
    A_MASK   = 3'd4,
    A_CFG    = 3'd5
  } upd_addr_e;

  localparam int FLAG_RDY = 0;
  localparam int FLAG_UNR = 1;
  localparam int NFLAGS   = 2;
endpackage

// File: rtl/upd_slot_pick.sv
module upd_slot_pick #(
  parameter int NCH = 4,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] en,
  input  logic [CW:0]    idx,
  output logic [CW-1:0]  slot,
  output logic [CW:0]    count
);
  logic [CW:0] c;
  // Rank search: the channel whose rank among enabled ones equals idx.
  always_comb begin
    c    = '0;
    slot = '0;
    for (int i = 0; i < NCH; i++) begin
      if (en[i]) begin
        if (c == idx) slot = CW'(i);
        c = c + 1'b1;
      end
    end
    count = c;
  end
endmodule

// File: rtl/upd_duty_bank.sv
module upd_duty_bank #(
  parameter int NCH    = 4,
  parameter int DUTY_W = 16,
  parameter int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        en,
  input  logic                  wr_en,
  input  logic [CW-1:0]         wr_slot,
  input  logic [DUTY_W-1:0]     wr_data,
  input  logic                  commit,
  output logic [NCH*DUTY_W-1:0] act
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DUTY_W-1:0] shadow_q;
    logic              hit;
    assign hit = wr_en && (wr_slot == CW'(ch));

    always_ff @(posedge clk) begin
      if (!rst_n)   shadow_q <= '0;
      else if (hit) shadow_q <= wr_data;
    end

    // A beat landing on the commit edge is part of the committed set.
    always_ff @(posedge clk) begin
      if (!rst_n)
        act[ch*DUTY_W +: DUTY_W] <= '0;
      else if (commit && en[ch])
        act[ch*DUTY_W +: DUTY_W] <= hit ? wr_data : shadow_q;
    end
  end

  // R6: active duty values move only on a commit
  a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act));
endmodule

// File: rtl/upd_cfg_bank.sv
module upd_cfg_bank
  import upd_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int PER_W = 16,
  parameter int DT_W  = 8,
  parameter int IV_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               period_tick,
  output logic [PER_W-1:0]   act_period,
  output logic [DT_W-1:0]    act_dt_hi,
  output logic [DT_W-1:0]    act_dt_lo,
  output logic [IV_W-1:0]    ival_sh,
  output logic [NFLAGS-1:0]  imask,
  output logic               cmp_mode,
  output logic               unlock_pend
);
  logic [PER_W-1:0]  per_sh;
  logic [2*DT_W-1:0] dt_sh;
  logic              unl_wr;
  logic              apply;
  upd_addr_e         a;

  assign a      = upd_addr_e'(reg_addr);
  assign unl_wr = reg_wr && (a == A_CTRL) && reg_wdata[0];
  assign apply  = period_tick && unlock_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_sh   <= '0;
      dt_sh    <= '0;
      ival_sh  <= '0;
      imask    <= '0;
      cmp_mode <= 1'b0;
    end else if (reg_wr) begin
      case (a)
        A_PERIOD: per_sh   <= reg_wdata[PER_W-1:0];
        A_DTIME:  dt_sh    <= reg_wdata[2*DT_W-1:0];
        A_IVAL:   ival_sh  <= reg_wdata[IV_W-1:0];
        A_MASK:   imask    <= reg_wdata[NFLAGS-1:0];
        A_CFG:    cmp_mode <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  // Unlock: a fresh write wins over a clear on the same boundary.
  always_ff @(posedge clk) begin
    if (!rst_n)      unlock_pend <= 1'b0;
    else if (unl_wr) unlock_pend <= 1'b1;
    else if (apply)  unlock_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_period <= '0;
      act_dt_hi  <= '0;
      act_dt_lo  <= '0;
    end else if (apply) begin
      act_period <= per_sh;
      act_dt_hi  <= dt_sh[2*DT_W-1:DT_W];
      act_dt_lo  <= dt_sh[DT_W-1:0];
    end
  end

  // R1: no unlock applied, period and dead times are frozen
  a_r1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(period_tick && unlock_pend) |=> $stable(act_period) && $stable(act_dt_hi) && $stable(act_dt_lo));
  // R2: the unlock bit is held until a boundary
  a_r2_unlock_held: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_pend && !period_tick |=> unlock_pend);
  // R2: a boundary consumes the unlock and installs the staged period
  a_r2_unlock_apply: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick && unlock_pend && !unl_wr |=> !unlock_pend && act_period == $past(per_sh));
endmodule

// File: rtl/sync_pwm_upd_ctrl.sv
module sync_pwm_upd_ctrl
  import upd_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DUTY_W = 16,
  parameter int REG_W  = 16,
  parameter int PER_W  = 16,
  parameter int DT_W   = 8,
  parameter int IV_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  period_tick,
  input  logic                  cmp_match,
  input  logic [NCH-1:0]        ch_en,
  input  logic                  dty_valid,
  output logic                  dty_ready,
  input  logic [DUTY_W-1:0]     dty_data,
  output logic                  dma_req,
  input  logic                  reg_wr,
  input  logic [2:0]            reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  input  logic                  stat_rd,
  output logic [NFLAGS-1:0]     stat_flags,
  output logic                  unlock_pend,
  output logic                  irq,
  output logic [PER_W-1:0]      act_period,
  output logic [DT_W-1:0]       act_dt_hi,
  output logic [DT_W-1:0]       act_dt_lo,
  output logic [NCH*DUTY_W-1:0] act_duty
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [IV_W-1:0]   ival_sh, ival_cnt;
  logic [NFLAGS-1:0] imask;
  logic              cmp_mode;
  logic [CW:0]       wr_cnt, cnt_eff, n_en;
  logic [CW-1:0]     slot;
  logic              armed, beat, commit_evt, open_evt, set_full, unr_evt;

  upd_cfg_bank #(.REG_W(REG_W), .PER_W(PER_W), .DT_W(DT_W), .IV_W(IV_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .period_tick(period_tick),
    .act_period(act_period), .act_dt_hi(act_dt_hi), .act_dt_lo(act_dt_lo),
    .ival_sh(ival_sh), .imask(imask), .cmp_mode(cmp_mode),
    .unlock_pend(unlock_pend)
  );

  upd_slot_pick #(.NCH(NCH), .CW(CW)) pick_i (
    .en(ch_en), .idx(wr_cnt), .slot(slot), .count(n_en)
  );

  upd_duty_bank #(.NCH(NCH), .DUTY_W(DUTY_W), .CW(CW)) bank_i (
    .clk(clk), .rst_n(rst_n), .en(ch_en), .wr_en(beat), .wr_slot(slot),
    .wr_data(dty_data), .commit(commit_evt && set_full), .act(act_duty)
  );

  assign dty_ready  = armed && (wr_cnt < n_en);
  assign dma_req    = dty_ready;
  assign beat       = dty_valid && dty_ready;
  assign cnt_eff    = wr_cnt + {{CW{1'b0}}, beat};
  assign commit_evt = period_tick && (ival_cnt == '0);
  assign set_full   = (n_en != '0) && (cnt_eff == n_en);
  assign unr_evt    = commit_evt && armed && (cnt_eff < n_en);
  assign open_evt   = cmp_mode ? cmp_match : commit_evt;

  // Interval down-counter; reloads from the staged interval at each commit.
  always_ff @(posedge clk) begin
    if (!rst_n)           ival_cnt <= '0;
    else if (commit_evt)  ival_cnt <= ival_sh;
    else if (period_tick) ival_cnt <= ival_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          wr_cnt <= '0;
    else if (commit_evt) wr_cnt <= '0;
    else if (beat)       wr_cnt <= wr_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          armed <= 1'b0;
    else if (open_evt)   armed <= 1'b1;
    else if (commit_evt) armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_flags <= '0;
    else begin
      if (open_evt)     stat_flags[FLAG_RDY] <= 1'b1;
      else if (stat_rd) stat_flags[FLAG_RDY] <= 1'b0;
      if (unr_evt)      stat_flags[FLAG_UNR] <= 1'b1;
      else if (stat_rd) stat_flags[FLAG_UNR] <= 1'b0;
    end
  end

  assign irq = |(stat_flags & imask);

  // R5: the last beat of a set drops ready on the next cycle
  a_r5_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    beat && (cnt_eff == n_en) && !commit_evt |=> !dty_ready);
  // R7: an incomplete set at commit raises underrun
  a_r7_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    unr_evt |=> stat_flags[FLAG_UNR]);
  // R8: a read with no new event clears the ready flag
  a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !open_evt |=> !stat_flags[FLAG_RDY]);
  // R3: a boundary off the commit count steps the counter down by one
  a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick && !commit_evt |=> ival_cnt == $past(ival_cnt) - 1'b1);
endmodule

// File: tb/sync_pwm_upd_ctrl_tb_top.sv
module sync_pwm_upd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic period_tick = 1'b0, cmp_match = 1'b0;
  logic [NCH-1:0] ch_en = '0;
  logic dty_valid = 1'b0, dty_ready;
  logic [DW-1:0] dty_data = '0;
  logic dma_req;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic stat_rd = 1'b0;
  logic [1:0] stat_flags;
  logic unlock_pend, irq;
  logic [15:0] act_period;
  logic [7:0] act_dt_hi, act_dt_lo;
  logic [NCH*DW-1:0] act_duty;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_pwm_upd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .cmp_match(cmp_match),
    .ch_en(ch_en), .dty_valid(dty_valid), .dty_ready(dty_ready), .dty_data(dty_data),
    .dma_req(dma_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .stat_rd(stat_rd), .stat_flags(stat_flags), .unlock_pend(unlock_pend), .irq(irq),
    .act_period(act_period), .act_dt_hi(act_dt_hi), .act_dt_lo(act_dt_lo),
    .act_duty(act_duty)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); period_tick = 1'b1;
    @(negedge clk); period_tick = 1'b0;
  endtask

  task automatic cmp_pulse();
    @(negedge clk); cmp_match = 1'b1;
    @(negedge clk); cmp_match = 1'b0;
  endtask

  task automatic stat_read();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic beat(input logic [DW-1:0] d);
    @(negedge clk); dty_valid = 1'b1; dty_data = d;
    @(negedge clk); dty_valid = 1'b0;
  endtask

  function automatic int popc(input logic [NCH-1:0] m);
    int c = 0;
    for (int i = 0; i < NCH; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic logic [DW-1:0] val(input int base, input int r);
    return DW'(base + r*3 + 1);
  endfunction

  // Expected active duty after a committed set: rank-ordered fill of enabled channels.
  function automatic logic [63:0] fill(input logic [63:0] prev, input logic [NCH-1:0] m, input int base);
    logic [63:0] e = prev;
    int r = 0;
    for (int i = 0; i < NCH; i++)
      if (m[i]) begin e[i*DW +: DW] = val(base, r); r++; end
    return e;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=%0h exp=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] e1, e3;
    do_reset();
    // R11: reset state
    chk("R11 duty", act_duty, 0);
    chk("R11 flags", {unlock_pend, irq, dma_req, dty_ready, stat_flags}, 0);
    chk("R11 period", {act_period, act_dt_hi, act_dt_lo}, 0);

    for (int m = 0; m < 16; m++) begin
      for (int u = 0; u < 3; u++) begin
        int n, b1, b2, b3;
        n = popc(4'(m));
        b1 = 16'h0100 * (m + 1) + u * 16'h10;
        b2 = b1 + 16'h2000;
        b3 = b1 + 16'h4000;
        do_reset();
        ch_en = 4'(m);
        reg_write(3'd2, 16'(u));
        reg_write(3'd4, 16'h3);
        tick();
        chk("R8 ready set at window open", 64'(stat_flags[0]), 1);
        chk("R5 req while window open", 64'(dma_req), 64'(n > 0));
        for (int k = 0; k < n; k++) beat(val(b1, k));
        chk("R5 req drops after last beat", {dma_req, dty_ready}, 0);
        repeat (u) tick();
        chk("R3 no commit before interval", act_duty, 0);
        tick();
        e1 = fill(64'd0, 4'(m), b1);
        chk("R4 R6 commit order", act_duty, e1);
        chk("R7 no underrun on full set", 64'(stat_flags[1]), 0);
        for (int k = 0; k < n - 1; k++) beat(val(b2, k));
        repeat (u + 1) tick();
        chk("R7 underrun flag", 64'(stat_flags[1]), 64'(n > 0));
        chk("R7 duty kept on underrun", act_duty, e1);
        chk("R9 irq", 64'(irq), 1);
        stat_read();
        chk("R8 read clears", 64'(stat_flags), 0);
        for (int k = 0; k < n; k++) beat(val(b3, k));
        repeat (u + 1) tick();
        e3 = fill(e1, 4'(m), b3);
        chk("R7 index restart", act_duty, e3);
      end
    end

    // R1 / R2: unlock path
    do_reset();
    reg_write(3'd0, 16'h1234);
    reg_write(3'd1, 16'h0A05);
    tick(); tick();
    chk("R1 period held without unlock", {act_period, act_dt_hi, act_dt_lo}, 0);
    reg_write(3'd3, 16'h0000);
    chk("R2 zero write ignored", 64'(unlock_pend), 0);
    reg_write(3'd3, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R2 unlock held", 64'(unlock_pend), 1);
    chk("R1 not applied before boundary", 64'(act_period), 0);
    tick();
    chk("R2 applied at boundary", {act_period, act_dt_hi, act_dt_lo}, 64'h1234_0A05);
    chk("R2 unlock clears", 64'(unlock_pend), 0);

    // R9: masking
    do_reset();
    reg_write(3'd4, 16'h2);
    tick();
    chk("R9 ready masked", {64'(stat_flags[0]), 64'(irq)} == {64'd1, 64'd0}, 1);
    reg_write(3'd4, 16'h1);
    chk("R9 ready unmasked", 64'(irq), 1);
    stat_read();
    chk("R9 irq after read", 64'(irq), 0);

    // R10: compare-match timing
    do_reset();
    ch_en = 4'b0101;
    reg_write(3'd5, 16'h1);
    reg_write(3'd2, 16'h1);
    tick();
    chk("R10 commit does not open", {stat_flags[0], dma_req}, 0);
    cmp_pulse();
    chk("R10 cmp opens", {stat_flags[0], dma_req}, 2'b11);
    beat(16'hAAA1); beat(16'hBBB2);
    chk("R5 req off after set", 64'(dma_req), 0);
    tick(); tick();
    chk("R10 R6 commit", act_duty, 64'h0000_BBB2_0000_AAA1);
    chk("R10 window closed after commit", 64'(dma_req), 0);
    cmp_pulse();
    chk("R10 reopened by cmp", 64'(dma_req), 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule